// File: doc/BRIEF.md
# Hidden Flash Zone Access Guard

This block sits in front of a two-bank flash array and decides, for every read, write or instruction fetch, whether the access may proceed. Each bank can hold one hidden zone. The zone is counted in 8-KB sectors. It begins at the bank's secure watermark start sector, which is supplied from outside, and ends at a programmable end sector. A bank's zone is hidden once both its enable bit and its hide bit are set. While a zone is hidden, any access that falls inside it is refused. The refusal comes back as a bus error with zeroed data.

Software reaches the configuration through a small write port. Only a secure requester may change it. The hide bit can only be set, and it stays set until reset. The zone bounds and the enable bit can change only while the bank's zone is not hidden and the device protection level is not level 2. The block also screens bank erase requests. An erase is aborted when the target bank holds a write-protected area or an enabled zone. The flash array, option loading and the watermark checker are outside the block.

Top module: `hz_guard`

## Requirements
- R1: An access address is given as byte-address bits 13 and up. The top bit of `acc_addr` selects the bank (0 or 1) and the bits below it are the sector index. A sector is inside a bank's zone when start ≤ sector ≤ end, with both bounds included.
- R2: An access is denied when the addressed bank's zone is enabled, its hide bit is set and the sector lies inside the zone. Every other access is allowed. Reads, writes and fetches are treated alike.
- R3: The response comes one cycle after `acc_valid`, through `resp_valid` and `resp_err`. A denied access gives `resp_err`=1 and `resp_rdata`=0 in that cycle. An allowed access gives `resp_err`=0 and passes `arr_rdata` through to `resp_rdata`.
- R4: A secure hide write with `cfg_hide`=1 sets the bank's hide bit from the next cycle. A hide write with `cfg_hide`=0 has no effect, and the bit stays set until reset.
- R5: A secure zone write (`cfg_end`, `cfg_en`) takes effect from the next cycle while the bank is not hidden and `lvl2` is low.
- R6: A secure zone write is ignored when the bank is hidden or `lvl2` is high. In that case `cfg_err` pulses in the next cycle.
- R7: A non-secure zone write or hide write is ignored, and `cfg_err` pulses in the next cycle.
- R8: One cycle after `erase_req`, exactly one of two outputs pulses. `erase_abort` pulses when `wrp_flag` of the target bank is set, or when that bank's zone is enabled with end ≥ start. Otherwise `erase_done` pulses.
- R9: Reset clears the end sector, the enable bit and the hide bit of both banks, and drives every response output low.
- R10: The two banks are configured and checked independently. A write, hide or zone in one bank has no effect on accesses to the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lvl2 | input | 1 | Device protection level 2 is active |
| wm_start | input | 2×SECT_W | Secure watermark start sector for each bank |
| wrp_flag | input | 2 | Bank holds a write-protected area |
| acc_valid | input | 1 | Access request (read, write or fetch) |
| acc_addr | input | SECT_W+1 | Address bits 13 and up: bank bit on top, sector below |
| arr_rdata | input | DATA_W | Array data in the response cycle |
| resp_valid | output | 1 | Response to the previous cycle's request |
| resp_err | output | 1 | Access denied (bus error) |
| resp_rdata | output | DATA_W | Returned data, zero when denied |
| cfg_zone_we | input | 1 | Zone bounds and enable write strobe |
| cfg_hide_we | input | 1 | Hide bit write strobe |
| cfg_bank | input | 1 | Target bank of a configuration write |
| cfg_secure | input | 1 | Writer is secure |
| cfg_end | input | SECT_W | New zone end sector |
| cfg_en | input | 1 | New zone enable |
| cfg_hide | input | 1 | Hide value (only 1 acts) |
| cfg_err | output | 1 | Configuration write was refused |
| erase_req | input | 1 | Bank erase request |
| erase_bank | input | 1 | Bank to erase |
| erase_done | output | 1 | Erase accepted |
| erase_abort | output | 1 | Erase aborted |

## Verification
The bench builds the guard with SECT_W=4, which gives 16 sectors per bank. With that size, the first and last sector, a single-sector zone and an empty zone (end below start) are all reached in a few directed steps. A random phase with periodic resets then runs through many hide, resize and erase interleavings across both banks. With the watermark starts at 2 and 5, each zone has sectors on both sides of it, so both inclusive bounds are exercised from inside and from outside.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int SECT_LSB  = 13;
    localparam int NUM_BANKS = 2;

    typedef enum logic [1:0] {
        ERS_NONE  = 2'd0,
        ERS_DONE  = 2'd1,
        ERS_ABORT = 2'd2
    } ers_e;
endpackage

// File: rtl/hz_zone_match.sv
module hz_zone_match #(
    parameter int SECT_W = 7
) (
    input  logic [SECT_W-1:0] sect,
    input  logic [SECT_W-1:0] start,
    input  logic [SECT_W-1:0] zend,
    input  logic              en,
    input  logic              hide,
    output logic              hit,
    output logic              area
);
    logic above_start, below_end;

    always_comb begin
        above_start = (sect >= start);
        below_end   = (sect <= zend);
        hit         = en && hide && above_start && below_end;
        area        = en && (zend >= start);
    end
endmodule

// File: rtl/hz_bank_cfg.sv
module hz_bank_cfg #(
    parameter int SECT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              zone_we,
    input  logic              hide_we,
    input  logic              wr_secure,
    input  logic              lvl2,
    input  logic [SECT_W-1:0] end_wr,
    input  logic              en_wr,
    input  logic              hide_wr,
    output logic [SECT_W-1:0] end_q,
    output logic              en_q,
    output logic              hide_q,
    output logic              reject
);
    typedef struct packed {
        logic [SECT_W-1:0] zend;
        logic              en;
        logic              hide;
    } cfg_t;

    cfg_t s_d, s_q;
    logic hidden_q;
    logic resize_ok;

    assign hidden_q = s_q.en && s_q.hide;
    assign end_q    = s_q.zend;
    assign en_q     = s_q.en;
    assign hide_q   = s_q.hide;

    always_comb begin
        s_d       = s_q;
        reject    = 1'b0;
        resize_ok = wr_secure && !hidden_q && !lvl2;
        if (zone_we) begin
            if (resize_ok) begin
                s_d.zend = end_wr;
                s_d.en   = en_wr;
            end else begin
                reject = 1'b1;
            end
        end
        if (hide_we) begin
            if (!wr_secure) begin
                reject = 1'b1;
            end else if (hide_wr) begin
                s_d.hide = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    a_r4_hide_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        hide_q |=> hide_q);
    a_r4_zero_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (hide_we && !hide_wr && !hide_q) |=> !hide_q);
    a_r5_resize_applied: assert property (@(posedge clk) disable iff (!rst_n)
        (zone_we && wr_secure && !(en_q && hide_q) && !lvl2)
        |=> (end_q == $past(end_wr)) && (en_q == $past(en_wr)));
    a_r6_locked_zone: assert property (@(posedge clk) disable iff (!rst_n)
        (zone_we && ((en_q && hide_q) || lvl2)) |=> $stable(end_q) && $stable(en_q));
    a_r7_nonsecure_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (zone_we && !wr_secure) |=> $stable(end_q) && $stable(en_q));
endmodule

// File: rtl/hz_guard.sv
module hz_guard
    import hz_pkg::*;
#(
    parameter int SECT_W = 7,
    parameter int DATA_W = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             lvl2,
    input  logic [NUM_BANKS-1:0][SECT_W-1:0] wm_start,
    input  logic [NUM_BANKS-1:0]             wrp_flag,
    input  logic                             acc_valid,
    input  logic [SECT_W:0]                  acc_addr,
    input  logic [DATA_W-1:0]                arr_rdata,
    output logic                             resp_valid,
    output logic                             resp_err,
    output logic [DATA_W-1:0]                resp_rdata,
    input  logic                             cfg_zone_we,
    input  logic                             cfg_hide_we,
    input  logic                             cfg_bank,
    input  logic                             cfg_secure,
    input  logic [SECT_W-1:0]                cfg_end,
    input  logic                             cfg_en,
    input  logic                             cfg_hide,
    output logic                             cfg_err,
    input  logic                             erase_req,
    input  logic                             erase_bank,
    output logic                             erase_done,
    output logic                             erase_abort
);
    localparam int BANK_BIT = SECT_W;

    typedef struct packed {
        logic rv;
        logic rerr;
        logic cerr;
        ers_e ers;
    } resp_t;

    resp_t s_d, s_q;

    logic [SECT_W-1:0]                acc_sect;
    logic                             acc_bank;
    logic [NUM_BANKS-1:0][SECT_W-1:0] zend;
    logic [NUM_BANKS-1:0]             zen, zhide, rej, hit, area;

    assign acc_bank = acc_addr[BANK_BIT];
    assign acc_sect = acc_addr[SECT_W-1:0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        hz_bank_cfg #(.SECT_W(SECT_W)) u_cfg (
            .clk       (clk),
            .rst_n     (rst_n),
            .zone_we   (cfg_zone_we && (cfg_bank == 1'(b))),
            .hide_we   (cfg_hide_we && (cfg_bank == 1'(b))),
            .wr_secure (cfg_secure),
            .lvl2      (lvl2),
            .end_wr    (cfg_end),
            .en_wr     (cfg_en),
            .hide_wr   (cfg_hide),
            .end_q     (zend[b]),
            .en_q      (zen[b]),
            .hide_q    (zhide[b]),
            .reject    (rej[b])
        );
        hz_zone_match #(.SECT_W(SECT_W)) u_match (
            .sect  (acc_sect),
            .start (wm_start[b]),
            .zend  (zend[b]),
            .en    (zen[b]),
            .hide  (zhide[b]),
            .hit   (hit[b]),
            .area  (area[b])
        );
    end

    always_comb begin
        s_d      = s_q;
        s_d.rv   = acc_valid;
        s_d.rerr = acc_valid && hit[acc_bank];
        s_d.cerr = |rej;
        if (!erase_req)
            s_d.ers = ERS_NONE;
        else if (wrp_flag[erase_bank] || area[erase_bank])
            s_d.ers = ERS_ABORT;
        else
            s_d.ers = ERS_DONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{rv: 1'b0, rerr: 1'b0, cerr: 1'b0, ers: ERS_NONE};
        else        s_q <= s_d;
    end

    assign resp_valid  = s_q.rv;
    assign resp_err    = s_q.rerr;
    assign resp_rdata  = s_q.rerr ? '0 : arr_rdata;
    assign cfg_err     = s_q.cerr;
    assign erase_done  = (s_q.ers == ERS_DONE);
    assign erase_abort = (s_q.ers == ERS_ABORT);

    a_r2_deny_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && hit[acc_bank]) |=> (resp_valid && resp_err));
    a_r3_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> (resp_rdata == '0));
    a_r3_err_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> !resp_err);
    a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({erase_done, erase_abort}));
    a_r8_wrp_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && wrp_flag[erase_bank]) |=> erase_abort);
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !erase_req |=> !(erase_done || erase_abort));
endmodule

// File: tb/sim_hz_guard.sv
module sim_hz_guard;
    localparam int SW = 4;
    localparam int DW = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lvl2 = 1'b0;
    logic [1:0][SW-1:0] wm_start;
    logic [1:0]        wrp_flag = 2'b00;
    logic              acc_valid = 1'b0;
    logic [SW:0]       acc_addr = '0;
    logic [DW-1:0]     arr_rdata = '0;
    logic              resp_valid, resp_err, cfg_err, erase_done, erase_abort;
    logic [DW-1:0]     resp_rdata;
    logic              cfg_zone_we = 1'b0, cfg_hide_we = 1'b0, cfg_bank = 1'b0;
    logic              cfg_secure = 1'b0, cfg_en = 1'b0, cfg_hide = 1'b0;
    logic [SW-1:0]     cfg_end = '0;
    logic              erase_req = 1'b0, erase_bank = 1'b0;

    always #2.5 clk = ~clk;

    hz_guard #(.SECT_W(SW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .lvl2(lvl2), .wm_start(wm_start),
        .wrp_flag(wrp_flag), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .arr_rdata(arr_rdata), .resp_valid(resp_valid), .resp_err(resp_err),
        .resp_rdata(resp_rdata), .cfg_zone_we(cfg_zone_we), .cfg_hide_we(cfg_hide_we),
        .cfg_bank(cfg_bank), .cfg_secure(cfg_secure), .cfg_end(cfg_end),
        .cfg_en(cfg_en), .cfg_hide(cfg_hide), .cfg_err(cfg_err),
        .erase_req(erase_req), .erase_bank(erase_bank),
        .erase_done(erase_done), .erase_abort(erase_abort)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    finished = 0;
    string cur_req = "R9";

    // behavioural reference model
    bit    m_en[2];
    bit    m_hide[2];
    int    m_end[2];
    bit    exp_rv, exp_err, exp_cerr, exp_done, exp_abort;
    string exp_tag = "R9";
    int    mb, ms, eb, cb;
    bit    mhit, mab, mrej;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_en[i] = 0; m_hide[i] = 0; m_end[i] = 0;
            end
            exp_rv <= 0; exp_err <= 0; exp_cerr <= 0;
            exp_done <= 0; exp_abort <= 0; exp_tag <= "R9";
        end else begin
            mb   = (int'(acc_addr) >> SW) & 1;
            ms   = int'(acc_addr) % (1 << SW);
            mhit = m_en[mb] && m_hide[mb] && ms >= int'(wm_start[mb]) && ms <= m_end[mb];
            exp_rv  <= acc_valid;
            exp_err <= acc_valid && mhit;
            exp_tag <= cur_req;
            eb  = int'(erase_bank);
            mab = wrp_flag[eb] || (m_en[eb] && m_end[eb] >= int'(wm_start[eb]));
            exp_done  <= erase_req && !mab;
            exp_abort <= erase_req && mab;
            mrej = 0;
            cb   = int'(cfg_bank);
            if (cfg_zone_we) begin
                if (cfg_secure && !(m_en[cb] && m_hide[cb]) && !lvl2) begin
                    m_end[cb] = int'(cfg_end);
                    m_en[cb]  = cfg_en;
                end else mrej = 1;
            end
            if (cfg_hide_we) begin
                if (!cfg_secure) mrej = 1;
                else if (cfg_hide) m_hide[cb] = 1;
            end
            exp_cerr <= mrej;
        end
    end

    task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                       input string tag, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            chk(DW'(resp_valid), DW'(exp_rv), exp_tag, "resp_valid");
            chk(DW'(resp_err), DW'(exp_err), exp_tag, "resp_err");
            chk(resp_rdata, exp_err ? '0 : arr_rdata, "R3", "resp_rdata");
            chk(DW'(cfg_err), DW'(exp_cerr), exp_tag, "cfg_err");
            chk(DW'(erase_done), DW'(exp_done), "R8", "erase_done");
            chk(DW'(erase_abort), DW'(exp_abort), "R8", "erase_abort");
        end
    end

    task automatic tick();
        @(posedge clk); #1;
        acc_valid = 0; cfg_zone_we = 0; cfg_hide_we = 0; erase_req = 0;
        arr_rdata = $urandom;
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
    endtask

    task automatic acc(input int bank, input int sect, input string tag);
        cur_req = tag;
        acc_valid = 1; acc_addr = (SW+1)'(bank * (1 << SW) + sect);
        arr_rdata = $urandom;
        tick();
    endtask

    task automatic zone_wr(input int bank, input bit sec, input int zend, input bit en,
                           input string tag);
        cur_req = tag;
        cfg_zone_we = 1; cfg_bank = bank[0]; cfg_secure = sec;
        cfg_end = SW'(zend); cfg_en = en;
        tick();
    endtask

    task automatic hide_wr(input int bank, input bit sec, input bit val, input string tag);
        cur_req = tag;
        cfg_hide_we = 1; cfg_bank = bank[0]; cfg_secure = sec; cfg_hide = val;
        tick();
    endtask

    task automatic erase(input int bank, input string tag);
        cur_req = tag;
        erase_req = 1; erase_bank = bank[0];
        tick();
    endtask

    initial begin
        wm_start[0] = 4'd2;
        wm_start[1] = 4'd5;
        do_reset();
        // R9: right after reset everything is open
        for (int s = 0; s < 16; s += 5) acc(0, s, "R9");
        // R5: zone set but not hidden stays open
        zone_wr(0, 1, 6, 1, "R5");
        acc(0, 2, "R5"); acc(0, 6, "R5");
        // R4: hide bank 0
        hide_wr(0, 1, 1, "R4");
        // R1: inclusive bounds and R2 denial
        acc(0, 1, "R1"); acc(0, 2, "R1"); acc(0, 4, "R2");
        acc(0, 6, "R1"); acc(0, 7, "R1");
        // R10: bank 1 same sectors unaffected
        acc(1, 2, "R10"); acc(1, 6, "R10");
        // R4: writing zero keeps it hidden
        hide_wr(0, 1, 0, "R4");
        acc(0, 3, "R4");
        // R6: resize refused while hidden
        zone_wr(0, 1, 15, 1, "R6"); tick();
        acc(0, 7, "R6"); acc(0, 6, "R6");
        // R7: non-secure writes refused
        zone_wr(1, 0, 5, 1, "R7"); tick();
        hide_wr(1, 0, 1, "R7"); tick();
        acc(1, 5, "R7");
        // R1: single-sector zone at the top bank
        zone_wr(1, 1, 5, 1, "R1");
        hide_wr(1, 1, 1, "R1");
        acc(1, 4, "R1"); acc(1, 5, "R1"); acc(1, 6, "R1");
        // R8: enabled zone aborts
        erase(0, "R8"); erase(1, "R8"); tick();

        do_reset();
        // R6: level 2 blocks resize on an open bank
        lvl2 = 1;
        zone_wr(0, 1, 3, 1, "R6"); tick();
        hide_wr(0, 1, 1, "R6");
        acc(0, 2, "R6");
        lvl2 = 0;
        zone_wr(0, 1, 3, 1, "R5");
        acc(0, 2, "R2"); acc(0, 3, "R2"); acc(0, 4, "R2");
        // R8: empty zone, plain bank, protected bank
        erase(1, "R8");
        zone_wr(1, 1, 2, 1, "R8");
        erase(1, "R8");
        wrp_flag[1] = 1;
        erase(1, "R8"); tick();
        wrp_flag[1] = 0;
        acc(0, 15, "R2"); acc(1, 15, "R2"); acc(1, 0, "R2");

        // random interleaving
        for (int i = 0; i < 600; i++) begin
            if (i % 150 == 149) do_reset();
            cur_req = "R2";
            acc_valid = $urandom_range(0, 1);
            acc_addr = (SW+1)'($urandom);
            arr_rdata = $urandom;
            lvl2 = ($urandom_range(0, 9) == 0);
            cfg_zone_we = ($urandom_range(0, 5) == 0);
            cfg_hide_we = ($urandom_range(0, 7) == 0);
            cfg_bank = 1'($urandom); cfg_secure = ($urandom_range(0, 3) != 0);
            cfg_end = SW'($urandom); cfg_en = 1'($urandom); cfg_hide = 1'($urandom);
            erase_req = ($urandom_range(0, 4) == 0);
            erase_bank = 1'($urandom);
            wrp_flag = 2'($urandom_range(0, 3) == 0 ? $urandom : 0);
            tick();
        end
        lvl2 = 0; wrp_flag = 0;
        tick(); tick();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired act=running exp=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule